// File: doc/BRIEF.md
# Instruction Cycle Phase Controller

This block sequences a small accumulator machine through its instruction cycle, one register transfer per clock, over a single shared internal bus. Every instruction begins with a fetch phase. Memory-operand instructions that carry the indirect bit pass through an indirect phase, which resolves the effective address. The execute phase carries out the operation. An interrupt phase then runs in place of the next fetch when a request is pending at the end of execute and interrupts are enabled.

The controller holds the machine registers: PC, MAR, MDR, IR, ACC, SP, the ALU input buffer Y and the ALU result buffer Z. For each step it drives a one-hot bus source select and a set of destination latch strobes. It also raises memory read and write requests, which are held until the memory answers with a ready. Interrupt entry pushes the return address onto a descending stack and then jumps to a fixed service vector. A return instruction pops the address back and re-enables interrupts.

Top module: `phase_ctl`

## Requirements
- R1: While reset is active and in the first cycle after it is released, the controller is in fetch step 0 with PC and ACC at zero, SP at SP_INIT, and only the PC bus driver and the MAR latch asserted.
- R2: `phase` is one-hot at all times: bit 0 fetch, bit 1 indirect, bit 2 execute, bit 3 interrupt.
- R3: At most one bus driver is asserted per cycle. `drv` bits: 0 PC, 1 MDR, 2 ACC, 3 Z, 4 SP, 5 IR address field, 6 vector. `lat` bits: 0 MAR, 1 MDR, 2 IR, 3 Y, 4 Z, 5 ACC, 6 PC.
- R4: Fetch takes these steps in order: PC to MAR; a memory read at that address; MDR to IR. PC is incremented by one in the final step, and `pc_inc` is asserted only during fetch.
- R5: A step that requests a memory read or write holds its step, address and request until `mem_ready` is high at a clock edge. Read and write are never requested together.
- R6: The instruction word is {opcode[15:13], indirect[12], address[11:0]}. Opcodes: 0 no-op, 1 load, 2 add, 3 store, 4 jump, 5 return, 6 and 7 no-op. For load, add and store with the indirect bit set, an indirect phase reads memory at the address field, and that word's low 12 bits become the effective address.
- R7: A jump executes in a single execute step that loads the address field into PC with no memory access, for a total of 4 + wait cycles. Its indirect bit is ignored.
- R8: Add loads the operand into Y, then ACC plus Y into Z, then Z into ACC. The sum wraps modulo 2^16.
- R9: Store writes ACC to memory at the effective address.
- R10: `irq` is sampled only in the last execute step. A request that is withdrawn before that step is ignored.
- R11: The interrupt phase decrements SP, writes the already-incremented PC to memory at the new SP, then loads VEC into PC and masks interrupts.
- R12: While masked, `irq` is ignored. Return reads PC from memory at SP, increments SP and re-enables interrupts. The instruction at the return address always executes before a request is taken again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_rdata | input | 16 | Memory read data, valid with mem_ready |
| mem_ready | input | 1 | Memory completes the pending access at this edge |
| irq | input | 1 | Interrupt request, level |
| mem_addr | output | 12 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MDR) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| phase | output | 4 | One-hot phase flags |
| step | output | 3 | Step within the phase |
| drv | output | 7 | One-hot bus source select |
| lat | output | 7 | Destination latch strobes |
| pc_inc | output | 1 | PC increment strobe |
| sp_dec | output | 1 | SP decrement strobe |
| sp_inc | output | 1 | SP increment strobe |
| pc_q | output | 12 | Current PC |
| acc_q | output | 16 | Current ACC |

## Verification
The hardest case to reach is the interaction between interrupt masking and return. The request must be held high across the service routine, the return, and the one instruction after it. The stimulus keeps `irq` asserted from a no-op through two complete entries, and expects the masked load and the return each to finish without an interrupt phase. It then expects a second push holding the next return address. A short pulse that is withdrawn during fetch, timed by watching `step`, covers the sampling point. Memory latency is varied per instruction, so that every wait path stalls at least once.

// File: rtl/phase_ctl.sv
module phase_ctl #(
  parameter int AW = 12,
  parameter int OPW = 3,
  parameter logic [AW-1:0] VEC = 'h080,
  parameter logic [AW-1:0] SP_INIT = 'h0F0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OPW+AW:0]       mem_rdata,
  input  logic                  mem_ready,
  input  logic                  irq,
  output logic [AW-1:0]         mem_addr,
  output logic [OPW+AW:0]       mem_wdata,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [3:0]            phase,
  output logic [2:0]            step,
  output logic [6:0]            drv,
  output logic [6:0]            lat,
  output logic                  pc_inc,
  output logic                  sp_dec,
  output logic                  sp_inc,
  output logic [AW-1:0]         pc_q,
  output logic [OPW+AW:0]       acc_q
);
  localparam int DW = OPW + 1 + AW;
  localparam int FE = 0, IND = 1, EX = 2, INT = 3;
  localparam int S_PC = 0, S_MDR = 1, S_ACC = 2, S_Z = 3, S_SP = 4, S_IRA = 5, S_VEC = 6;
  localparam int D_MAR = 0, D_MDR = 1, D_IR = 2, D_Y = 3, D_Z = 4, D_ACC = 5, D_PC = 6;
  localparam logic [OPW-1:0] OP_LDA = OPW'(1), OP_ADD = OPW'(2), OP_STA = OPW'(3),
                             OP_JMP = OPW'(4), OP_RET = OPW'(5);

  logic [3:0]    ph, nph;
  logic [2:0]    t;
  logic [AW-1:0] pc, mar, sp;
  logic [DW-1:0] mdr, ir, acc, y, z, bus;
  logic          ie, last, set_ie, clr_ie, stall;
  logic [6:0]    d, l;
  logic          rd, wr, pinc, sdec, sinc;

  wire [OPW-1:0] op      = ir[DW-1 -: OPW];
  wire           ea_ind  = ir[AW] && (op == OP_LDA || op == OP_ADD || op == OP_STA);
  wire [OPW-1:0] new_op  = mdr[DW-1 -: OPW];
  wire           new_ind = mdr[AW] && (new_op == OP_LDA || new_op == OP_ADD || new_op == OP_STA);
  wire           ea_src  = ea_ind ? S_MDR[0] : 1'b0;

  always_comb begin
    d = '0; l = '0; rd = 1'b0; wr = 1'b0; pinc = 1'b0; sdec = 1'b0; sinc = 1'b0;
    last = 1'b0; set_ie = 1'b0; clr_ie = 1'b0; nph = 4'b0001;
    if (ph[FE]) begin
      case (t)
        3'd0: begin d[S_PC] = 1'b1; l[D_MAR] = 1'b1; end
        3'd1: rd = 1'b1;
        default: begin
          d[S_MDR] = 1'b1; l[D_IR] = 1'b1; pinc = 1'b1; last = 1'b1;
          nph = new_ind ? 4'b0010 : 4'b0100;
        end
      endcase
    end else if (ph[IND]) begin
      case (t)
        3'd0: begin d[S_IRA] = 1'b1; l[D_MAR] = 1'b1; end
        default: begin rd = 1'b1; last = 1'b1; nph = 4'b0100; end
      endcase
    end else if (ph[EX]) begin
      nph = (irq && ie) ? 4'b1000 : 4'b0001;
      case (op)
        OP_LDA, OP_ADD, OP_STA: begin
          if (t == 3'd0) begin
            if (ea_src) d[S_MDR] = 1'b1; else d[S_IRA] = 1'b1;
            l[D_MAR] = 1'b1;
          end else if (op == OP_STA) begin
            if (t == 3'd1) begin d[S_ACC] = 1'b1; l[D_MDR] = 1'b1; end
            else begin wr = 1'b1; last = 1'b1; end
          end else if (t == 3'd1) begin
            rd = 1'b1;
          end else if (op == OP_LDA) begin
            d[S_MDR] = 1'b1; l[D_ACC] = 1'b1; last = 1'b1;
          end else begin
            case (t)
              3'd2: begin d[S_MDR] = 1'b1; l[D_Y] = 1'b1; end
              3'd3: begin d[S_ACC] = 1'b1; l[D_Z] = 1'b1; end
              default: begin d[S_Z] = 1'b1; l[D_ACC] = 1'b1; last = 1'b1; end
            endcase
          end
        end
        OP_JMP: begin d[S_IRA] = 1'b1; l[D_PC] = 1'b1; last = 1'b1; end
        OP_RET: begin
          case (t)
            3'd0: begin d[S_SP] = 1'b1; l[D_MAR] = 1'b1; end
            3'd1: rd = 1'b1;
            default: begin
              d[S_MDR] = 1'b1; l[D_PC] = 1'b1; sinc = 1'b1; set_ie = 1'b1; last = 1'b1;
            end
          endcase
        end
        default: last = 1'b1;
      endcase
    end else begin
      case (t)
        3'd0: sdec = 1'b1;
        3'd1: begin d[S_SP] = 1'b1; l[D_MAR] = 1'b1; end
        3'd2: begin d[S_PC] = 1'b1; l[D_MDR] = 1'b1; end
        3'd3: wr = 1'b1;
        default: begin d[S_VEC] = 1'b1; l[D_PC] = 1'b1; clr_ie = 1'b1; last = 1'b1; end
      endcase
    end
  end

  assign bus = ({DW{d[S_PC]}}  & DW'(pc))  | ({DW{d[S_MDR]}} & mdr) |
               ({DW{d[S_ACC]}} & acc)      | ({DW{d[S_Z]}}   & z)   |
               ({DW{d[S_SP]}}  & DW'(sp))  | ({DW{d[S_IRA]}} & DW'(ir[AW-1:0])) |
               ({DW{d[S_VEC]}} & DW'(VEC));

  assign stall = (rd || wr) && !mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= 4'b0001; t <= '0; pc <= '0; mar <= '0; sp <= SP_INIT;
      mdr <= '0; ir <= '0; acc <= '0; y <= '0; z <= '0; ie <= 1'b1;
    end else if (!stall) begin
      if (l[D_MAR]) mar <= bus[AW-1:0];
      if (l[D_MDR]) mdr <= bus;
      else if (rd)  mdr <= mem_rdata;
      if (l[D_IR])  ir  <= bus;
      if (l[D_Y])   y   <= bus;
      if (l[D_Z])   z   <= bus + y;
      if (l[D_ACC]) acc <= bus;
      if (l[D_PC])  pc  <= bus[AW-1:0];
      else if (pinc) pc <= pc + 1'b1;
      if (sdec) sp <= sp - 1'b1;
      else if (sinc) sp <= sp + 1'b1;
      if (set_ie) ie <= 1'b1;
      else if (clr_ie) ie <= 1'b0;
      if (last) begin ph <= nph; t <= '0; end
      else t <= t + 1'b1;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = rd;
  assign mem_wr    = wr;
  assign phase     = ph;
  assign step      = t;
  assign drv       = d;
  assign lat       = l;
  assign pc_inc    = pinc;
  assign sp_dec    = sdec;
  assign sp_inc    = sinc;
  assign pc_q      = pc;
  assign acc_q     = acc;
endmodule

// File: rtl/phase_ctl_chk.sv
module phase_ctl_chk #(
  parameter int AW = 12,
  parameter logic [AW-1:0] VEC = 'h080
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    phase,
  input logic [2:0]    step,
  input logic [6:0]    drv,
  input logic [6:0]    lat,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          pc_inc,
  input logic [AW-1:0] pc_q
);
  a_r2_phase_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot(phase));
  a_r3_one_driver: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(drv));
  a_r4_inc_in_fetch: assert property (@(posedge clk) disable iff (!rst_n) pc_inc |-> phase[0]);
  a_r5_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr) && $stable(step)));
  a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(step)));
  a_r5_no_rd_wr: assert property (@(posedge clk) disable iff (!rst_n) !(mem_rd && mem_wr));
  a_r10_int_after_ex: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase[3]) |-> $past(phase[2]));
  a_r11_vector_load: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[3] && drv[6] && lat[6]) |=> (pc_q == VEC && phase[0]));
endmodule

bind phase_ctl phase_ctl_chk #(.AW(AW), .VEC(VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .step(step), .drv(drv), .lat(lat),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .pc_inc(pc_inc), .pc_q(pc_q)
);

// File: tb/sim_phase_ctl.sv
module sim_phase_ctl;
  logic        clk = 1'b0, rst_n = 1'b0, mem_ready = 1'b0, irq = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [11:0] mem_addr, pc_q;
  logic [15:0] mem_wdata, acc_q;
  logic        mem_rd, mem_wr, pc_inc, sp_dec, sp_inc;
  logic [3:0]  phase;
  logic [2:0]  step;
  logic [6:0]  drv, lat;

  phase_ctl u0 (.clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .phase(phase), .step(step), .drv(drv), .lat(lat), .pc_inc(pc_inc), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .pc_q(pc_q), .acc_q(acc_q));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, mlat = 0, cnt = 0, wd = 0, conflicts = 0, stray_inc = 0;
  logic [15:0] mem [256];
  logic [2:0]  st0;
  logic [11:0] ad0;
  bit          q_wr[$];
  logic [11:0] q_addr[$];
  logic [15:0] q_data[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [11:0] a, input logic [15:0] dt, input string tag);
    q_wr.push_back(wr); q_addr.push_back(a); q_data.push_back(dt); q_tag.push_back(tag);
  endtask

  function automatic logic [15:0] enc(input int op, input bit ind, input logic [11:0] a);
    return {op[2:0], ind, a};
  endfunction

  always @(negedge clk) begin
    if (rst_n && drv != 0 && (drv & (drv - 7'd1)) != 0) conflicts++;
    if (rst_n && pc_inc && !phase[0]) stray_inc++;
    if (mem_ready) mem_ready = 1'b0;
    else if (rst_n && (mem_rd || mem_wr)) begin
      if (cnt == 0) begin st0 = step; ad0 = mem_addr; end
      if (cnt >= mlat) begin
        if (mlat > 0)
          chk(step == st0 && mem_addr == ad0, "R5", "held step/address",
              {17'd0, step, mem_addr}, {17'd0, st0, ad0});
        cnt = 0;
        mem_ready = 1'b1;
        if (mem_rd) mem_rdata = mem[mem_addr[7:0]];
        else mem[mem_addr[7:0]] = mem_wdata;
        if (q_wr.size() == 0) chk(1'b0, "R4", "unexpected access", {19'd0, mem_wr, mem_addr}, 0);
        else begin
          automatic bit ew = q_wr.pop_front();
          automatic logic [11:0] ea = q_addr.pop_front();
          automatic logic [15:0] ed = q_data.pop_front();
          automatic string tg = q_tag.pop_front();
          chk(mem_wr == ew && mem_addr == ea, tg, "access kind/address",
              {19'd0, mem_wr, mem_addr}, {19'd0, ew, ea});
          if (ew) chk(mem_wdata == ed, tg, "write data", {16'd0, mem_wdata}, {16'd0, ed});
        end
      end else cnt++;
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  always @(negedge clk) begin
    wd++;
    if (wd > 20000) begin
      chk(1'b0, "R2", "watchdog", wd, 20000);
      summary();
    end
  end

  task automatic run1(input int l, output int cyc, output logic [3:0] seen);
    mlat = l; cyc = 0; seen = '0;
    do begin
      seen |= phase;
      @(negedge clk);
      cyc++;
    end while (!(phase == 4'b0001 && step == 3'd0));
  endtask

  task automatic fetch_exp(input logic [11:0] a, input string tag);
    push(1'b0, a, mem[a[7:0]], tag);
  endtask

  initial begin
    int cy;
    logic [3:0] sn;
    logic [15:0] sum;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[8'h00] = enc(1, 0, 12'h040);
    mem[8'h01] = enc(2, 0, 12'h041);
    mem[8'h02] = enc(2, 1, 12'h042);
    mem[8'h03] = enc(3, 1, 12'h044);
    mem[8'h04] = enc(4, 1, 12'h010);
    mem[8'h10] = enc(0, 0, 12'h000);
    mem[8'h11] = enc(7, 0, 12'h000);
    mem[8'h12] = enc(0, 0, 12'h000);
    mem[8'h13] = enc(3, 0, 12'h051);
    mem[8'h14] = enc(4, 0, 12'h014);
    mem[8'h80] = enc(1, 0, 12'h045);
    mem[8'h81] = enc(5, 0, 12'h000);
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'h0F0F; mem[8'h42] = 16'h0043;
    mem[8'h43] = 16'hFFFF; mem[8'h44] = 16'h0050; mem[8'h45] = 16'h0007;

    repeat (3) @(negedge clk);
    chk(phase == 4'b0001 && step == 0, "R1", "phase/step in reset", {25'd0, phase, step}, 32'h8);
    rst_n = 1'b1;
    chk(pc_q == 0 && acc_q == 0, "R1", "pc/acc", {4'd0, pc_q, acc_q}, 0);
    chk(drv == 7'b1 && lat == 7'b1, "R1", "drv/lat", {18'd0, drv, lat}, 32'h81);

    fetch_exp(12'h000, "R4"); push(1'b0, 12'h040, 0, "R6");
    run1(0, cy, sn);
    chk(acc_q == 16'h1234 && pc_q == 12'h001, "R4", "load acc/pc", {4'd0, pc_q, acc_q}, 32'h0011234);

    fetch_exp(12'h001, "R4"); push(1'b0, 12'h041, 0, "R8");
    run1(1, cy, sn);
    chk(acc_q == 16'h2143, "R8", "add", acc_q, 32'h2143);

    sum = 16'h1234 + 16'h0F0F + 16'hFFFF;
    fetch_exp(12'h002, "R4"); push(1'b0, 12'h042, 0, "R6"); push(1'b0, 12'h043, 0, "R8");
    run1(2, cy, sn);
    chk(acc_q == sum, "R8", "indirect add with wrap", acc_q, sum);
    chk(sn == 4'b0111, "R6", "phases seen", sn, 4'b0111);

    fetch_exp(12'h003, "R4"); push(1'b0, 12'h044, 0, "R6"); push(1'b1, 12'h050, sum, "R9");
    run1(3, cy, sn);
    chk(sn == 4'b0111, "R6", "store phases", sn, 4'b0111);

    fetch_exp(12'h004, "R7");
    run1(0, cy, sn);
    chk(pc_q == 12'h010, "R7", "jump target", pc_q, 12'h010);
    chk(sn == 4'b0101 && cy == 4, "R7", "jump phases/cycles", {sn, 28'(cy)}, {4'b0101, 28'd4});

    fetch_exp(12'h010, "R10");
    mlat = 0; irq = 1'b1; cy = 0; sn = '0;
    do begin
      sn |= phase;
      if (phase == 4'b0001 && step == 3'd2) irq = 1'b0;
      @(negedge clk);
      cy++;
    end while (!(phase == 4'b0001 && step == 3'd0));
    chk(sn == 4'b0101 && pc_q == 12'h011, "R10", "withdrawn request", {sn, 16'd0, pc_q}, 32'h50000011);

    irq = 1'b1;
    fetch_exp(12'h011, "R11"); push(1'b1, 12'h0EF, 16'h0012, "R11");
    run1(2, cy, sn);
    chk(sn == 4'b1101, "R10", "interrupt phase after execute", sn, 4'b1101);
    chk(pc_q == 12'h080, "R11", "vector", pc_q, 12'h080);

    fetch_exp(12'h080, "R12"); push(1'b0, 12'h045, 0, "R12");
    run1(0, cy, sn);
    chk(sn == 4'b0101 && acc_q == 16'h0007, "R12", "masked", {sn, 12'd0, acc_q}, 32'h50000007);

    fetch_exp(12'h081, "R12"); push(1'b0, 12'h0EF, 0, "R12");
    run1(1, cy, sn);
    chk(sn == 4'b0101 && pc_q == 12'h012, "R12", "return", {sn, 16'd0, pc_q}, 32'h50000012);

    fetch_exp(12'h012, "R12"); push(1'b1, 12'h0EF, 16'h0013, "R12");
    run1(0, cy, sn);
    chk(sn == 4'b1101 && pc_q == 12'h080, "R12", "re-enabled", {sn, 16'd0, pc_q}, 32'hD0000080);
    irq = 1'b0;

    fetch_exp(12'h080, "R12"); push(1'b0, 12'h045, 0, "R12");
    run1(0, cy, sn);
    fetch_exp(12'h081, "R12"); push(1'b0, 12'h0EF, 0, "R11");
    run1(0, cy, sn);
    chk(pc_q == 12'h013, "R11", "second return", pc_q, 12'h013);

    fetch_exp(12'h013, "R9"); push(1'b1, 12'h051, 16'h0007, "R9");
    run1(1, cy, sn);
    chk(pc_q == 12'h014, "R4", "pc after store", pc_q, 12'h014);
    chk(q_wr.size() == 0, "R4", "pending accesses", q_wr.size(), 0);
    chk(conflicts == 0, "R3", "bus conflicts", conflicts, 0);
    chk(stray_inc == 0, "R4", "increment outside fetch", stray_inc, 0);
    summary();
  end
endmodule